// File: doc/BRIEF.md
# Shared-Pattern Module Group Tester

This block runs a built-in self-test session on a group of identical adders that are tested together. Two pseudo-random generators with different feedback polynomials produce the left and the right operand. Every adder in the group gets the same operand pair on every cycle. An n-way equality checker compares all adder results in each cycle. While the results agree, one multiple-input signature register folds the common result into a signature. The first disagreement ends the session at once and flags an error.

A controller pulses `start` with a pattern count and an expected signature. The block then runs on its own. It raises `done` for one cycle and reports `pass` and `err`, which hold until the next session. A per-module defect input flips the least significant result bit of selected adders. This lets the checker and the compactor be exercised from outside.

Top module: `pattern_group_bist`

## Requirements
- R1: After reset `busy`, `done`, `pass` and `err` are 0 and `signature` is 0.
- R2: A `start` sampled while idle loads both generators with their seeds, clears the signature and latches `test_len` and `expect_sig`. With N = max(`test_len`,1) patterns, `done` is high for exactly one cycle, N clock edges after the edge that sampled `start`, and `busy` is high during those N cycles.
- R3: The left operand is a right-shifting Galois generator with mask 0xB8 and seed 0x01. The right operand is a second generator with mask 0x8E and seed 0xA5. Both step once per compacted pattern, every adder receives this same pair, and neither generator ever holds zero.
- R4: In each run cycle without disagreement, the signature becomes ((s >> 1) XOR (s[0] ? 0x95 : 0)) XOR r, where s is the signature and r is the common 8-bit sum (left + right) mod 256.
- R5: When any two adder results differ in a run cycle, the session stops on that edge. `done` pulses, `err` is set, `pass` is 0, and that cycle's result is not compacted into the signature.
- R6: When a session ends without disagreement, `pass` is 1 exactly when the final signature equals the latched `expect_sig`. `pass` and `err` never both read 1, and they and `signature` hold while idle until the next `start`.
- R7: `start` is ignored while `busy`: the session length and results are those of the original request.
- R8: Bit i of `defect_en` inverts bit 0 of adder i's result. While idle it has no effect on any output. When all adders carry it, no disagreement is seen, and the signature follows R4 with the flipped sums.
- R9: A `test_len` of 0 runs exactly one pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a session when idle |
| test_len | input | 16 | Number of patterns to apply |
| expect_sig | input | 8 | Signature a good group should produce |
| defect_en | input | 3 | Per-adder result LSB inversion |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle end-of-session pulse |
| pass | output | 1 | Clean session with matching signature |
| err | output | 1 | Disagreement between adders stopped the session |
| signature | output | 8 | Current compactor contents |

## Verification
Directed sessions of length 0, 1 and 255 pin down the seeds, the step order and the done timing. A wrong expected signature separates the signature compare from the disagreement path. A defect on one or two adders, injected at chosen cycles, shows that the checker stops the session and freezes the compactor at the right pattern. A defect on all adders shows that agreement alone does not mean pass. A second `start` in the middle of a run shows it has no effect on the session. Seeded random lengths, expected values and defect timings then mix these cases, and each outcome is compared with a bench model of the generators and the compactor.

// File: rtl/pgb_pkg.sv
package pgb_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;

  // one right-shift step of a Galois generator, operands zero-extended to 32 bits
  function automatic logic [31:0] galois_step(input logic [31:0] s, input logic [31:0] mask);
    galois_step = (s >> 1) ^ ({32{s[0]}} & mask);
  endfunction

  // signature register step: generator step folded with incoming data
  function automatic logic [31:0] misr_step(input logic [31:0] s, input logic [31:0] mask,
                                            input logic [31:0] d);
    misr_step = galois_step(s, mask) ^ d;
  endfunction

endpackage

// File: rtl/pgb_lfsr.sv
module pgb_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         advance,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb q_next = W'(pgb_pkg::galois_step(32'(q), 32'(TAPS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= SEED;
    else if (load)    q <= SEED;
    else if (advance) q <= q_next;
  end

  assert_gen_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n) q != '0);
  assert_gen_seeded_R2: assert property (@(posedge clk) disable iff (!rst_n) load |=> q == SEED);

endmodule

// File: rtl/pgb_adder.sv
module pgb_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         defect,
  output logic [W-1:0] sum
);
  always_comb sum = (a + b) ^ {{(W-1){1'b0}}, defect};
endmodule

// File: rtl/pgb_eq_cmp.sv
module pgb_eq_cmp #(
  parameter int N = 3,
  parameter int W = 8
) (
  input  logic [N-1:0][W-1:0] vals,
  output logic                differ,
  output logic [W-1:0]        agreed
);
  logic [N-1:0] neq;

  assign neq[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_cmp
    assign neq[i] = (vals[i] != vals[0]);
  end

  assign differ = |neq;
  assign agreed = vals[0];

  always_comb begin
    if (!differ) begin
      for (int j = 0; j < N; j++) begin
        assert_agree_R5: assert (vals[j] == vals[N-1]);
      end
    end
  end
endmodule

// File: rtl/pgb_misr.sv
module pgb_misr #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'h95
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         capture,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb q_next = W'(pgb_pkg::misr_step(32'(q), 32'(TAPS), 32'(din)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (clear)   q <= '0;
    else if (capture) q <= q_next;
  end

  assert_sig_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n) clear |=> q == '0);
  assert_sig_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
                                       (!clear && !capture) |=> $stable(q));

endmodule

// File: rtl/pattern_group_bist.sv
module pattern_group_bist #(
  parameter int WIDTH = 8,
  parameter int NMOD  = 3,
  parameter int LEN_W = 16,
  parameter logic [WIDTH-1:0] LEFT_TAPS  = 8'hB8,
  parameter logic [WIDTH-1:0] LEFT_SEED  = 8'h01,
  parameter logic [WIDTH-1:0] RIGHT_TAPS = 8'h8E,
  parameter logic [WIDTH-1:0] RIGHT_SEED = 8'hA5,
  parameter logic [WIDTH-1:0] MISR_TAPS  = 8'h95
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] test_len,
  input  logic [WIDTH-1:0] expect_sig,
  input  logic [NMOD-1:0]  defect_en,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             err,
  output logic [WIDTH-1:0] signature
);
  import pgb_pkg::*;

  localparam int CNT_W = LEN_W + 1;

  run_state_t            state;
  logic [LEN_W-1:0]      len_q;
  logic [WIDTH-1:0]      exp_q;
  logic [CNT_W-1:0]      cnt;
  logic [CNT_W-1:0]      cnt_inc;
  logic                  launch;
  logic                  step;
  logic                  last_pat;
  logic                  differ;
  logic [WIDTH-1:0]      agreed;
  logic [WIDTH-1:0]      sig_next;
  logic [WIDTH-1:0]      left_op;
  logic [WIDTH-1:0]      right_op;
  logic [NMOD-1:0][WIDTH-1:0] mod_out;

  assign busy     = (state == ST_RUN);
  assign launch   = (state == ST_IDLE) && start;
  assign cnt_inc  = cnt + 1'b1;
  assign last_pat = busy && (cnt_inc >= {1'b0, len_q});
  assign step     = busy && !differ;
  assign sig_next = WIDTH'(misr_step(32'(signature), 32'(MISR_TAPS), 32'(agreed)));

  pgb_lfsr #(.W(WIDTH), .TAPS(LEFT_TAPS), .SEED(LEFT_SEED)) u_gen_left (
    .clk(clk), .rst_n(rst_n), .load(launch), .advance(step), .q(left_op)
  );

  pgb_lfsr #(.W(WIDTH), .TAPS(RIGHT_TAPS), .SEED(RIGHT_SEED)) u_gen_right (
    .clk(clk), .rst_n(rst_n), .load(launch), .advance(step), .q(right_op)
  );

  for (genvar m = 0; m < NMOD; m++) begin : g_mod
    pgb_adder #(.W(WIDTH)) u_add (
      .a(left_op), .b(right_op), .defect(defect_en[m]), .sum(mod_out[m])
    );
  end

  pgb_eq_cmp #(.N(NMOD), .W(WIDTH)) u_cmp (
    .vals(mod_out), .differ(differ), .agreed(agreed)
  );

  pgb_misr #(.W(WIDTH), .TAPS(MISR_TAPS)) u_sig (
    .clk(clk), .rst_n(rst_n), .clear(launch), .capture(step), .din(agreed), .q(signature)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      len_q <= '0;
      exp_q <= '0;
      cnt   <= '0;
      done  <= 1'b0;
      pass  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            len_q <= test_len;
            exp_q <= expect_sig;
            cnt   <= '0;
            pass  <= 1'b0;
            err   <= 1'b0;
          end
        end
        ST_RUN: begin
          if (differ) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            err   <= 1'b1;
            pass  <= 1'b0;
          end else if (last_pat) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            pass  <= (sig_next == exp_q);
          end else begin
            cnt <= cnt_inc;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_done_ends_run_R2: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  assert_stop_on_mismatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
                                               (busy && differ) |=> (!busy && err && done));
  assert_sig_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
                                         (busy && differ) |=> $stable(signature));
  assert_pass_clean_R6: assert property (@(posedge clk) disable iff (!rst_n) !(pass && err));
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
                                        (!busy && !start) |=>
                                        ($stable(signature) && $stable(pass) && $stable(err)));
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
                                            (busy && start && !differ && !last_pat) |=>
                                            (busy && cnt == $past(cnt_inc)));

endmodule

// File: tb/pattern_group_bist_test.sv
module pattern_group_bist_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] test_len = '0;
  logic [7:0]  expect_sig = '0;
  logic [2:0]  defect_en = '0;
  logic        busy, done, pass, err;
  logic [7:0]  signature;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  pattern_group_bist uut (
    .clk(clk), .rst_n(rst_n), .start(start), .test_len(test_len), .expect_sig(expect_sig),
    .defect_en(defect_en), .busy(busy), .done(done), .pass(pass), .err(err),
    .signature(signature)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string what, input int actual, input int expected);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, actual, expected);
    end
  endtask

  function automatic logic [7:0] gstep(input logic [7:0] s, input logic [7:0] m);
    if (s[0]) return {1'b0, s[7:1]} ^ m;
    return {1'b0, s[7:1]};
  endfunction

  // signature after 'count' compacted patterns; sums from index inv_from on get LSB flipped
  function automatic logic [7:0] model_sig(input int count, input int inv_from);
    logic [7:0] a = 8'h01, b = 8'hA5, s = 8'h00, r;
    for (int i = 0; i < count; i++) begin
      r = a + b;
      if (inv_from >= 0 && i >= inv_from) r[0] = ~r[0];
      s = gstep(s, 8'h95) ^ r;
      a = gstep(a, 8'hB8);
      b = gstep(b, 8'h8E);
    end
    return s;
  endfunction

  task automatic run_session(input int len, input bit good_exp, input int def_at,
                             input logic [2:0] dmask, input int ign_at, input string tag);
    int n = (len == 0) ? 1 : len;
    bit mism = (def_at >= 0) && (def_at < n) && (dmask != 3'b000) && (dmask != 3'b111);
    bit allbad = (def_at >= 0) && (def_at < n) && (dmask == 3'b111);
    int exp_k = mism ? def_at + 1 : n;
    logic [7:0] msig = mism ? model_sig(def_at, -1) : model_sig(n, allbad ? def_at : -1);
    logic [7:0] good = model_sig(n, -1);
    logic [7:0] ex = good_exp ? good : (good ^ 8'h5A);
    int k = 0;
    bit seen = 0;
    bit busy_ok = 1;
    @(negedge clk);
    start = 1'b1; test_len = 16'(len); expect_sig = ex;
    @(negedge clk);
    start = 1'b0;
    while (!seen && k < 5000) begin
      if (!busy) busy_ok = 0;
      if (k == def_at) defect_en = dmask;
      if (k == ign_at) begin start = 1'b1; test_len = 16'd3; expect_sig = 8'h00; end
      @(negedge clk);
      start = 1'b0;
      k++;
      if (done) seen = 1;
    end
    check(seen && k == exp_k, {tag, " R2 done timing (cycles)"}, k, exp_k);
    check(busy_ok, {tag, " R2 busy during run"}, busy_ok, 1);
    check(err == mism, {tag, " R5 err"}, err, mism);
    check(signature == msig, {tag, " R3/R4 signature"}, signature, msig);
    check(pass == (!mism && msig == ex), {tag, " R6 pass"}, pass, (!mism && msig == ex));
    defect_en = 3'b000;
    @(negedge clk);
    check(!done && !busy, {tag, " R2 done single cycle"}, done, 0);
    check(signature == msig && err == mism, {tag, " R6 hold after done"}, signature, msig);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] held;
    int len;
    void'($urandom(32'd7177));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !pass && !err, "R1 reset flags", {busy, done, pass, err}, 0);
    check(signature == 8'h00, "R1 reset signature", signature, 0);

    run_session(1, 1, -1, 3'b000, -1, "len1");
    run_session(0, 1, -1, 3'b000, -1, "R9 len0");
    run_session(255, 1, -1, 3'b000, -1, "len255");
    run_session(20, 0, -1, 3'b000, -1, "R6 wrong exp");
    run_session(10, 1, 0, 3'b010, -1, "R5 defect m1 at0");
    run_session(30, 1, 7, 3'b100, -1, "R5 defect m2 at7");
    run_session(25, 1, 12, 3'b011, -1, "R5 defect two at12");
    run_session(12, 1, 4, 3'b111, -1, "R8 all defective");
    run_session(40, 1, -1, 3'b000, 5, "R7 start ignored");

    // R8 defect while idle changes nothing
    held = signature;
    defect_en = 3'b101;
    repeat (4) @(negedge clk);
    check(signature == held && !busy && !done && pass, "R8 idle defect no effect", signature, held);
    defect_en = 3'b000;

    for (int it = 0; it < 10; it++) begin
      int da = -1;
      logic [2:0] dm = 3'b000;
      int ig = -1;
      len = $urandom_range(1, 300);
      if ($urandom_range(0, 3) == 0) begin
        da = $urandom_range(0, len - 1);
        dm = 3'($urandom_range(1, 7));
      end
      if (len > 3 && $urandom_range(0, 3) == 0) ig = $urandom_range(0, len - 3);
      run_session(len, 1'($urandom_range(0, 1)), da, dm, ig, "random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule